// File: doc/BRIEF.md
# Pin Controller with Interrupt Sensing

This block is a memory-mapped controller for up to 32 general-purpose pins. Each pin runs in one of three modes: plain input, driven output, or interrupt source. For an interrupt source, software picks level or edge sensing and the active sense (high/rising or low/falling). The block keeps a pending view per pin and a per-pin enable. It drives a single interrupt request that is the OR of all enabled pending pins.

Software reaches the block through a flat 32-bit register port. Writes take effect at the clock edge. Reads are combinational from the address. Pad inputs pass through a two-stage synchronizer before any use. Edge detection compares the synchronized, polarity-adjusted level with its copy from one cycle earlier. The pad side is exposed as an output-enable vector and an output-value vector for the chip's tristate buffers.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, pad_oe is all 0 and irq is 0. All pins are plain inputs with high/rising sense and level sensing, all enables are off and all edge flags are clear.
- R2: Byte offsets 0x00 (mode, 1 = interrupt source), 0x04 (direction, 1 = output), 0x08 (output value), 0x20 (sense, 1 = low/falling) and 0x24 (sensing, 1 = edge) read back what was written. pad_oe is direction AND NOT mode. pad_out equals the output value.
- R3: Offset 0x0C returns the pad level two clock edges after the pad changes. Bits whose pin is driving (pad_oe = 1) read 0, and software reads an output's state from 0x08.
- R4: A pin in interrupt mode with level sensing shows pending at 0x10 while its synchronized pad equals 1 XOR its sense bit. Nothing is stored: the bit follows the pad.
- R5: A pin in interrupt mode with edge sensing sets a sticky flag on a 0-to-1 transition (sense 0) or a 1-to-0 transition (sense 1). The flag is visible at 0x10 by the third edge after the pad change and stays set after the pad returns.
- R6: Writing offset 0x14 clears the edge flag of every pin whose data bit is 1. Bits written 0 leave their flags untouched.
- R7: Writing offset 0x18 disables the interrupt of every pin whose data bit is 0. Bits written 1 leave their enable unchanged. Reading 0x18 returns the enable vector (1 = enabled).
- R8: Writing offset 0x1C enables every pin whose data bit is 1. Bits written 0 leave their enable unchanged.
- R9: irq is 1 exactly when some pin is both pending and enabled.
- R10: Pins in plain I/O mode never show pending. Writes to 0x0C and 0x10 are ignored. Offsets 0x14, 0x1C and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | NUM_PINS | Raw pad levels, asynchronous |
| pad_oe | output | NUM_PINS | Per-pin output enable |
| pad_out | output | NUM_PINS | Per-pin output value |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong enable bit or a wrong edge flag shows on irq in the cycle after the register write that should have set it. The enable vector and the pending view are also visible on the next read of 0x18 or 0x10. A synchronizer of the wrong depth moves the first change of 0x0C away from the second edge, and the bench samples on both sides of that edge. A lost or spurious edge flag persists until cleared, so the bench sees it at 0x10 on every later read. It also drives irq as soon as the pin is enabled.

// File: rtl/gpio_ctrl_pkg.sv
// Package: register offsets and shared widths for the pin controller.
// Assumes byte addressing with word-aligned 32-bit registers.
package gpio_ctrl_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DOUT   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_DIN    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_PEND   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_ACK    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_UNMASK = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_SENSE  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_EDGE   = 8'h24;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: multi-stage synchronizer for the pad inputs.
// Assumes each pad bit is asynchronous and independent; no bus coherency.
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage captures the raw pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage resamples the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_sense.sv
// Module: per-pin interrupt sensing.
// The sense bit inverts the synchronized level. Level pins report that
// level live, and edge pins latch a sticky flag on a 0->1 change of it.
// Assumes the input is already synchronized. A change of the sense bit can
// itself look like an edge, so software acknowledges after reconfiguring.
module gpio_irq_sense #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] lvl_sync,
    input  logic [NUM_PINS-1:0] irq_mode,
    input  logic [NUM_PINS-1:0] edge_sel,
    input  logic [NUM_PINS-1:0] sense_low,
    input  logic [NUM_PINS-1:0] ack,
    output logic [NUM_PINS-1:0] edge_hit,
    output logic [NUM_PINS-1:0] flag_q,
    output logic [NUM_PINS-1:0] pend
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic active;
        logic active_d;

        assign active      = lvl_sync[i] ^ sense_low[i];
        assign edge_hit[i] = active & ~active_d & irq_mode[i] & edge_sel[i];

        // Delayed copy of the polarity-adjusted level for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) active_d <= 1'b0;
            else        active_d <= active;
        end

        // Sticky edge flag: a new edge wins over a same-cycle acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q[i] <= 1'b0;
            else if (edge_hit[i]) flag_q[i] <= 1'b1;
            else if (ack[i])      flag_q[i] <= 1'b0;
        end

        assign pend[i] = irq_mode[i] & (edge_sel[i] ? flag_q[i] : active);
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: top of the pin controller.
// It holds the configuration registers, decodes the register port,
// drives the pad enables and values, and combines the interrupts.
// Assumes one write per cycle, with no byte enables. Reads are combinational.
module gpio_irq_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic                irq
);
    localparam int N = NUM_PINS;

    logic [N-1:0] mode_q, dir_q, dout_q, sense_q, edge_q, en_q;
    logic [N-1:0] lvl_sync, edge_hit, flag_q, pend, ack_vec;
    logic [N-1:0] wbits;

    assign wbits = bus_wdata[N-1:0];

    gpio_in_sync #(.WIDTH(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (lvl_sync)
    );

    // Acknowledge vector, active only in the cycle of a write to 0x14.
    always_comb begin
        ack_vec = '0;
        if (bus_we && bus_addr == OFS_ACK) ack_vec = wbits;
    end

    gpio_irq_sense #(.NUM_PINS(N)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_sync  (lvl_sync),
        .irq_mode  (mode_q),
        .edge_sel  (edge_q),
        .sense_low (sense_q),
        .ack       (ack_vec),
        .edge_hit  (edge_hit),
        .flag_q    (flag_q),
        .pend      (pend)
    );

    // Configuration registers and enable set/clear ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            dir_q   <= '0;
            dout_q  <= '0;
            sense_q <= '0;
            edge_q  <= '0;
            en_q    <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                OFS_MODE:   mode_q  <= wbits;
                OFS_DIR:    dir_q   <= wbits;
                OFS_DOUT:   dout_q  <= wbits;
                OFS_SENSE:  sense_q <= wbits;
                OFS_EDGE:   edge_q  <= wbits;
                OFS_MASK:   en_q    <= en_q & wbits;
                OFS_UNMASK: en_q    <= en_q | wbits;
                default:    ;
            endcase
        end
    end

    assign pad_oe  = dir_q & ~mode_q;
    assign pad_out = dout_q;
    assign irq     = |(pend & en_q);

    // Read multiplexer; write-only and unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_MODE:  bus_rdata[N-1:0] = mode_q;
            OFS_DIR:   bus_rdata[N-1:0] = dir_q;
            OFS_DOUT:  bus_rdata[N-1:0] = dout_q;
            OFS_DIN:   bus_rdata[N-1:0] = lvl_sync & ~pad_oe;
            OFS_PEND:  bus_rdata[N-1:0] = pend;
            OFS_MASK:  bus_rdata[N-1:0] = en_q;
            OFS_SENSE: bus_rdata[N-1:0] = sense_q;
            OFS_EDGE:  bus_rdata[N-1:0] = edge_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Module: property checker for the pin controller, attached by bind.
// It observes ports and the state that separate submodules drive.
module gpio_irq_ctrl_chk
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic                irq,
    input logic [NUM_PINS-1:0] mode_q,
    input logic [NUM_PINS-1:0] en_q,
    input logic [NUM_PINS-1:0] flag_q,
    input logic [NUM_PINS-1:0] edge_hit,
    input logic [NUM_PINS-1:0] pend
);
    localparam int N = NUM_PINS;

    // R1: one cycle in reset leaves no driven pad and no request.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && !irq));

    // R10: pins in plain I/O mode never report pending.
    a_r10_io_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~mode_q) == '0);

    // R6: acknowledged flags drop unless a new edge arrived at the same time.
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_ACK) |=>
        ((flag_q & $past(bus_wdata[N-1:0]) & ~$past(edge_hit)) == '0));

    // R5: without an acknowledge, no edge flag ever falls.
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == OFS_ACK) |=> (($past(flag_q) & ~flag_q) == '0));

    // R7: a mask write leaves no enable where a 0 was written.
    a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_MASK) |=> ((en_q & ~$past(bus_wdata[N-1:0])) == '0));

    // R8: an unmask write leaves every written 1 enabled.
    a_r8_unmask: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_UNMASK) |=> (($past(bus_wdata[N-1:0]) & ~en_q) == '0));

    // R9: a request needs at least one pending pin.
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend != '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .mode_q    (mode_q),
    .en_q      (en_q),
    .flag_q    (flag_q),
    .edge_hit  (edge_hit),
    .pend      (pend)
);

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe, pad_out;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        #500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v, pat, sen;
        cycles(3);
        rst_n = 1'b1;

        // R1: reset state of every offset and of the outputs.
        for (int a = 0; a <= 'h28; a += 4) begin
            rd(8'(a), v);
            check($sformatf("R1 reset read 0x%0h", a), v, 32'h0);
        end
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R2: read back of configuration registers and pad drive.
        wr(8'h00, 32'hF0F0_1234); wr(8'h04, 32'hFF00_FF00); wr(8'h08, 32'hDEAD_BEEF);
        wr(8'h20, 32'h1357_9BDF); wr(8'h24, 32'h2468_ACE0);
        rd(8'h00, v); check("R2 mode", v, 32'hF0F0_1234);
        rd(8'h04, v); check("R2 dir", v, 32'hFF00_FF00);
        rd(8'h08, v); check("R2 dout", v, 32'hDEAD_BEEF);
        rd(8'h20, v); check("R2 sense", v, 32'h1357_9BDF);
        rd(8'h24, v); check("R2 edge", v, 32'h2468_ACE0);
        check("R2 pad_oe", pad_oe, 32'hFF00_FF00 & ~32'hF0F0_1234);
        check("R2 pad_out", pad_out, 32'hDEAD_BEEF);
        wr(8'h00, 0); wr(8'h20, 0); wr(8'h24, 0);

        // R3: two-edge input latency and masking of driven pins.
        wr(8'h04, 32'h0000_FFFF); wr(8'h08, 32'h1234_5678);
        pad_in = 32'hA5A5_A5A5;
        cycles(1);
        rd(8'h0C, v); check("R3 after one edge", v, 32'h0);
        cycles(1);
        rd(8'h0C, v); check("R3 after two edges", v, 32'hA5A5_0000);
        rd(8'h08, v); check("R3 output value at 0x08", v, 32'h1234_5678);
        check("R3 pad_out", pad_out, 32'h1234_5678);

        // R10: read-only writes ignored, I/O pins never pending.
        wr(8'h0C, 32'h0); wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h0C, v); check("R10 write to 0x0C ignored", v, 32'hA5A5_0000);
        pad_in = 32'hFFFF_FFFF; cycles(3);
        rd(8'h10, v); check("R10 I/O pins not pending", v, 32'h0);
        rd(8'h14, v); check("R10 0x14 reads 0", v, 32'h0);
        rd(8'h1C, v); check("R10 0x1C reads 0", v, 32'h0);
        rd(8'h28, v); check("R10 unmapped reads 0", v, 32'h0);
        wr(8'h04, 0);

        // R4: level sensing sweep over patterns and both sense settings.
        wr(8'h00, 32'hFFFF_FFFF);
        for (int s = 0; s < 3; s++) begin
            sen = (s == 0) ? 32'h0 : (s == 1) ? 32'hFFFF_FFFF : 32'h0F0F_3C3C;
            wr(8'h20, sen);
            for (int p = 0; p < 6; p++) begin
                pat = 32'h9E37_79B9 * (p + 1) ^ (32'h1 << (p * 5));
                pad_in = pat; cycles(2);
                rd(8'h10, v);
                check($sformatf("R4 level s=%0d p=%0d", s, p), v, pat ^ sen);
            end
        end

        // R5: edge sensing, both directions, sticky after return.
        sen = 32'h0F0F_0F0F;
        pad_in = 32'h0;
        wr(8'h24, 32'hFFFF_FFFF); wr(8'h20, sen);
        cycles(4);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h10, v); check("R5 cleared before edges", v, 32'h0);
        pad_in = 32'hFFFF_FFFF; cycles(2);
        rd(8'h10, v); check("R5 not yet after two edges", v, 32'h0);
        cycles(1);
        rd(8'h10, v); check("R5 rising flags", v, ~sen);
        pad_in = 32'h0; cycles(3);
        rd(8'h10, v); check("R5 falling flags, rising sticky", v, 32'hFFFF_FFFF);

        // R6: write-one-to-clear acknowledge.
        wr(8'h14, 32'h0000_FFFF);
        rd(8'h10, v); check("R6 low half cleared", v, 32'hFFFF_0000);
        wr(8'h14, 32'h0);
        rd(8'h10, v); check("R6 zero write no effect", v, 32'hFFFF_0000);

        // R8, R9: single-pin unmask sweep against pending 0xFFFF0000.
        for (int k = 0; k < 32; k++) begin
            wr(8'h18, 32'h0);
            check($sformatf("R9 all masked k=%0d", k), {31'h0, irq}, 32'h0);
            wr(8'h1C, 32'h1 << k);
            rd(8'h18, v); check($sformatf("R8 unmask k=%0d", k), v, 32'h1 << k);
            check($sformatf("R9 irq k=%0d", k), {31'h0, irq}, {31'h0, (k >= 16)});
        end

        // R7: mask write only clears bits written 0.
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h18, ~32'h00FF_00FF);
        rd(8'h18, v); check("R7 mask pattern", v, 32'hFF00_FF00);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, v); check("R7 all-ones write no effect", v, 32'hFF00_FF00);
        wr(8'h1C, 32'h0);
        rd(8'h18, v); check("R8 zero unmask no effect", v, 32'hFF00_FF00);
        check("R9 irq from enabled pending", {31'h0, irq}, 32'h1);
        wr(8'h18, 32'h00FF_FFFF);
        check("R9 irq off when pending masked", {31'h0, irq}, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule